// File: doc/BRIEF.md
# Camera PHY Test-Port Configuration Receiver

This block is the receiving end of a slow, software-driven parallel test port. It is used to program the configuration registers of a camera serial receiver PHY. A host toggles four wires: a test strobe, a phase select, an 8-bit bus and a clear line. The block samples them with a fast system clock and decodes each two-phase access. On a strobe fall with the phase select high, the bus value becomes the current register code. On a strobe rise with the phase select low, the bus value is stored into the register that the current code selects.

The stored values drive the PHY configuration outputs:
- the clock-lane control byte;
- one control byte for each data lane, together with the 6-bit frequency band field taken from it;
- the settle-time control byte;
- a flag for normal operation, which is raised when the current code is zero.

A read-back bus always returns the contents of the register that the current code addresses. All four test wires are asynchronous to the system clock. Each one passes through a two-stage synchroniser before any edge is detected.

Top module: `phy_tst_port`

## Requirements
- R1: After reset, the current code is 0x00 and every configuration output and the read-back bus are zero.
- R2: A falling edge of the test strobe while the phase select is high loads the bus value as the current code; the read-back bus then shows the register addressed by that code.
- R3: A rising edge of the test strobe while the phase select is low writes the bus value into the register selected by the current code.
- R4: A rising strobe edge with the phase select high writes nothing, and a falling strobe edge with the phase select low leaves the current code unchanged.
- R5: The register codes are: clock-lane control at 0x34; data lanes 0, 1, 2 and 3 at 0x44, 0x54, 0x84 and 0x94; settle-time control at 0x75.
- R6: While the clear line is high, the current code and all registers are forced to zero.
- R7: When the current code is not one of the codes in R5, the read-back bus is zero and a write changes no output.
- R8: The band output of each data lane, 6 bits per lane with lane 0 in the lowest bits, equals bits 6:1 of that lane's control register.
- R9: The normal-operation output is high exactly when the current code is 0x00.
- R10: A strobe transition that has been stable before a system clock edge affects the outputs at the third rising system clock edge after it, and not at the second.
- R11: The current code persists across data phases, so repeated data phases without a new address phase rewrite the same register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_clk_i | input | 1 | Test strobe, idles high |
| test_en_i | input | 1 | Phase select: high selects the address phase, low selects the data phase |
| test_din_i | input | 8 | Shared code/data bus |
| test_clr_i | input | 1 | Clear of the code and the registers, active high |
| test_dout_o | output | 8 | Contents of the currently addressed register |
| normal_mode_o | output | 1 | High when the current code is 0x00 |
| clk_lane_ctl_o | output | 8 | Clock-lane control register |
| data_lane_ctl_o | output | 32 | Data-lane control registers, lane 0 in bits 7:0 |
| lane_band_o | output | 24 | Per-lane band field, lane 0 in bits 5:0 |
| settle_ctl_o | output | 8 | Settle-time control register |

## Verification
Ordinary address-then-data accesses go to every implemented code, each with a distinct value. A mismatch then shows whether a write landed in the wrong register or the band slice is shifted. Crossed patterns check that the phase select is honoured on the correct strobe edge:
- a rise with the phase select high;
- a fall with the phase select low.

Without crossed patterns, a decoder that ignores the phase select would go unnoticed. Accesses to an unused code and to code 0x00 check that read-back is zero there and that writes are dropped. Repeated data phases check that the code persists. Sampling one cycle early and then on time around a strobe rise pins the three-cycle latency.

// File: rtl/phy_tst_pkg.sv
package phy_tst_pkg;

  localparam logic [7:0] CODE_NORMAL = 8'h00;
  localparam logic [7:0] CODE_CLK    = 8'h34;
  localparam logic [7:0] CODE_SETTLE = 8'h75;
  localparam int unsigned MAX_LANES  = 4;

  function automatic logic [7:0] lane_code(input int unsigned idx);
    case (idx)
      0:       lane_code = 8'h44;
      1:       lane_code = 8'h54;
      2:       lane_code = 8'h84;
      default: lane_code = 8'h94;
    endcase
  endfunction

  function automatic logic code_is_impl(input logic [7:0] c, input int unsigned lanes);
    logic hit;
    hit = (c == CODE_CLK) || (c == CODE_SETTLE);
    for (int unsigned i = 0; i < MAX_LANES; i++) begin
      if (i < lanes && c == lane_code(i)) hit = 1'b1;
    end
    code_is_impl = hit;
  endfunction

endpackage

// File: rtl/phy_tst_sync.sv
module phy_tst_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  generate
    if (STAGES <= 1) begin : g_single
      logic [W-1:0] stage_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= RST_VAL;
        else        stage_q <= d_i;
      end
      assign q_o = stage_q;
    end else begin : g_chain
      logic [STAGES-1:0][W-1:0] stage_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= {STAGES{RST_VAL}};
        else        stage_q <= {stage_q[STAGES-2:0], d_i};
      end
      assign q_o = stage_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/phy_tst_edge.sv
module phy_tst_edge #(
  parameter logic IDLE_LVL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic rise_o,
  output logic fall_o
);

  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= IDLE_LVL;
    else        prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
  assign fall_o = ~lvl_i & prev_q;

endmodule

// File: rtl/phy_tst_regfile.sv
module phy_tst_regfile
  import phy_tst_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned LANES  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr_i,
  input  logic                    code_ld_i,
  input  logic                    wr_en_i,
  input  logic [DATA_W-1:0]       din_i,
  output logic [DATA_W-1:0]       code_o,
  output logic [DATA_W-1:0]       clk_ctl_o,
  output logic [LANES*DATA_W-1:0] lane_ctl_o,
  output logic [DATA_W-1:0]       settle_ctl_o,
  output logic [DATA_W-1:0]       dout_o
);

  logic [DATA_W-1:0] code_q, code_d;
  logic [DATA_W-1:0] clk_q, clk_d;
  logic [DATA_W-1:0] settle_q, settle_d;
  logic [DATA_W-1:0] lane_q [LANES];
  logic              hit_clk, hit_settle;
  logic [LANES-1:0]  hit_lane;

  // address decode of the current code
  always_comb begin
    hit_clk    = (code_q == DATA_W'(CODE_CLK));
    hit_settle = (code_q == DATA_W'(CODE_SETTLE));
    for (int unsigned i = 0; i < LANES; i++) begin
      hit_lane[i] = (code_q == DATA_W'(lane_code(i)));
    end
  end

  // next state: clear dominates, then address phase / data phase
  always_comb begin
    code_d   = code_q;
    clk_d    = clk_q;
    settle_d = settle_q;
    if (clr_i) begin
      code_d   = '0;
      clk_d    = '0;
      settle_d = '0;
    end else begin
      if (code_ld_i)             code_d   = din_i;
      if (wr_en_i && hit_clk)    clk_d    = din_i;
      if (wr_en_i && hit_settle) settle_d = din_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q   <= '0;
      clk_q    <= '0;
      settle_q <= '0;
    end else begin
      code_q   <= code_d;
      clk_q    <= clk_d;
      settle_q <= settle_d;
    end
  end

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [DATA_W-1:0] lane_d;
      logic              lane_en;

      assign lane_en = clr_i | (wr_en_i & hit_lane[g]);

      always_comb begin
        lane_d = lane_q[g];
        if (clr_i)        lane_d = '0;
        else if (lane_en) lane_d = din_i;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       lane_q[g] <= '0;
        else if (lane_en) lane_q[g] <= lane_d;
      end

      assign lane_ctl_o[g*DATA_W +: DATA_W] = lane_q[g];
    end
  endgenerate

  // read-back of the addressed register
  always_comb begin
    dout_o = '0;
    if (hit_clk)    dout_o = clk_q;
    if (hit_settle) dout_o = settle_q;
    for (int unsigned i = 0; i < LANES; i++) begin
      if (hit_lane[i]) dout_o = lane_q[i];
    end
  end

  assign code_o       = code_q;
  assign clk_ctl_o    = clk_q;
  assign settle_ctl_o = settle_q;

endmodule

// File: rtl/phy_tst_port.sv
module phy_tst_port
  import phy_tst_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned LANES       = 4,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned BAND_LSB    = 1,
  parameter int unsigned BAND_W      = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    test_clk_i,
  input  logic                    test_en_i,
  input  logic [DATA_W-1:0]       test_din_i,
  input  logic                    test_clr_i,
  output logic [DATA_W-1:0]       test_dout_o,
  output logic                    normal_mode_o,
  output logic [DATA_W-1:0]       clk_lane_ctl_o,
  output logic [LANES*DATA_W-1:0] data_lane_ctl_o,
  output logic [LANES*BAND_W-1:0] lane_band_o,
  output logic [DATA_W-1:0]       settle_ctl_o
);

  localparam int unsigned SYNC_W = DATA_W + 3;
  localparam logic [SYNC_W-1:0] SYNC_RST = {1'b0, 1'b0, 1'b1, {DATA_W{1'b0}}};

  logic              rst_ns;
  logic [SYNC_W-1:0] raw_bus, sync_bus;
  logic              clr_s, en_s, tck_s;
  logic [DATA_W-1:0] din_s;
  logic              rise_ev, fall_ev;
  logic              code_ld, wr_en;
  logic [DATA_W-1:0] code_q;

  // reset: asserted asynchronously, released through two flops
  phy_tst_sync #(.W(1), .STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  (1'b1),
    .q_o  (rst_ns)
  );

  assign raw_bus = {test_clr_i, test_en_i, test_clk_i, test_din_i};

  phy_tst_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_in_sync (
    .clk  (clk),
    .rst_n(rst_ns),
    .d_i  (raw_bus),
    .q_o  (sync_bus)
  );

  assign din_s = sync_bus[DATA_W-1:0];
  assign tck_s = sync_bus[DATA_W];
  assign en_s  = sync_bus[DATA_W+1];
  assign clr_s = sync_bus[DATA_W+2];

  phy_tst_edge #(.IDLE_LVL(1'b1)) u_tck_edge (
    .clk   (clk),
    .rst_n (rst_ns),
    .lvl_i (tck_s),
    .rise_o(rise_ev),
    .fall_o(fall_ev)
  );

  assign code_ld = fall_ev & en_s;
  assign wr_en   = rise_ev & ~en_s;

  phy_tst_regfile #(.DATA_W(DATA_W), .LANES(LANES)) u_regs (
    .clk         (clk),
    .rst_n       (rst_ns),
    .clr_i       (clr_s),
    .code_ld_i   (code_ld),
    .wr_en_i     (wr_en),
    .din_i       (din_s),
    .code_o      (code_q),
    .clk_ctl_o   (clk_lane_ctl_o),
    .lane_ctl_o  (data_lane_ctl_o),
    .settle_ctl_o(settle_ctl_o),
    .dout_o      (test_dout_o)
  );

  generate
    for (genvar g = 0; g < LANES; g++) begin : g_band
      assign lane_band_o[g*BAND_W +: BAND_W] =
        data_lane_ctl_o[g*DATA_W + BAND_LSB +: BAND_W];
    end
  endgenerate

  assign normal_mode_o = (code_q == DATA_W'(CODE_NORMAL));

endmodule

// File: rtl/phy_tst_port_chk.sv
module phy_tst_port_chk
  import phy_tst_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned LANES  = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    fall_ev,
  input logic                    rise_ev,
  input logic                    en_s,
  input logic                    clr_s,
  input logic [DATA_W-1:0]       din_s,
  input logic [DATA_W-1:0]       code_q,
  input logic [DATA_W-1:0]       test_dout_o,
  input logic [DATA_W-1:0]       clk_lane_ctl_o,
  input logic [LANES*DATA_W-1:0] data_lane_ctl_o,
  input logic [DATA_W-1:0]       settle_ctl_o
);

  AST_CODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_ev && en_s && !clr_s) |=> (code_q == $past(din_s))); // R2

  AST_CLK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_ev && !en_s && !clr_s && code_q == DATA_W'(CODE_CLK)) |=>
      (clk_lane_ctl_o == $past(din_s))); // R3

  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!(fall_ev && en_s) && !clr_s) |=> $stable(code_q)); // R4

  AST_SETTLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!(rise_ev && !en_s && code_q == DATA_W'(CODE_SETTLE)) && !clr_s) |=>
      $stable(settle_ctl_o)); // R4

  AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    clr_s |=> (code_q == '0 && test_dout_o == '0 && clk_lane_ctl_o == '0 &&
               settle_ctl_o == '0 && data_lane_ctl_o == '0)); // R6

  AST_UNIMPL_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !code_is_impl(8'(code_q), LANES) |-> (test_dout_o == '0)); // R7

endmodule

bind phy_tst_port phy_tst_port_chk #(.DATA_W(DATA_W), .LANES(LANES)) u_chk (
  .clk            (clk),
  .rst_n          (rst_ns),
  .fall_ev        (fall_ev),
  .rise_ev        (rise_ev),
  .en_s           (en_s),
  .clr_s          (clr_s),
  .din_s          (din_s),
  .code_q         (code_q),
  .test_dout_o    (test_dout_o),
  .clk_lane_ctl_o (clk_lane_ctl_o),
  .data_lane_ctl_o(data_lane_ctl_o),
  .settle_ctl_o   (settle_ctl_o)
);

// File: tb/phy_tst_port_bench.sv
`timescale 1ns/1ps
module phy_tst_port_bench;

  logic        clk;
  logic        rst_n;
  logic        tck, ten, tclr;
  logic [7:0]  tdin;
  logic [7:0]  tdout;
  logic        normal;
  logic [7:0]  clk_ctl, settle_ctl;
  logic [31:0] lane_ctl;
  logic [23:0] band;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  // reference model state
  logic [7:0] m_code, m_clk, m_settle;
  logic [7:0] m_lane [4];

  phy_tst_port u_phy_tst_port (
    .clk            (clk),
    .rst_n          (rst_n),
    .test_clk_i     (tck),
    .test_en_i      (ten),
    .test_din_i     (tdin),
    .test_clr_i     (tclr),
    .test_dout_o    (tdout),
    .normal_mode_o  (normal),
    .clk_lane_ctl_o (clk_ctl),
    .data_lane_ctl_o(lane_ctl),
    .lane_band_o    (band),
    .settle_ctl_o   (settle_ctl)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [7:0] lane_addr(input int i);
    case (i)
      0: return 8'h44;
      1: return 8'h54;
      2: return 8'h84;
      default: return 8'h94;
    endcase
  endfunction

  function automatic logic [7:0] exp_read();
    if (m_code == 8'h34) return m_clk;
    if (m_code == 8'h75) return m_settle;
    for (int i = 0; i < 4; i++) if (m_code == lane_addr(i)) return m_lane[i];
    return 8'h00;
  endfunction

  function automatic void m_write(input logic [7:0] d);
    if (m_code == 8'h34) m_clk = d;
    if (m_code == 8'h75) m_settle = d;
    for (int i = 0; i < 4; i++) if (m_code == lane_addr(i)) m_lane[i] = d;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // wait n rising edges, then sit mid-cycle
  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #5;
  endtask

  task automatic check_all(input string req);
    chk(req, "dout", {24'h0, tdout}, {24'h0, exp_read()});
    chk(req, "normal", {31'h0, normal}, {31'h0, (m_code == 8'h00)});
    chk(req, "clk_ctl", {24'h0, clk_ctl}, {24'h0, m_clk});
    chk(req, "settle", {24'h0, settle_ctl}, {24'h0, m_settle});
    for (int i = 0; i < 4; i++) begin
      chk(req, "lane_ctl", {24'h0, lane_ctl[i*8 +: 8]}, {24'h0, m_lane[i]});
      chk("R8", "band", {26'h0, band[i*6 +: 6]}, {26'h0, m_lane[i][6:1]});
    end
  endtask

  task automatic addr_phase(input logic [7:0] code);
    ten = 1'b1; tdin = code; cyc(4);
    tck = 1'b0; cyc(4);
    m_code = code;
  endtask

  task automatic data_phase(input logic [7:0] data);
    ten = 1'b0; tdin = data; cyc(4);
    tck = 1'b1; cyc(4);
    m_write(data);
  endtask

  task automatic access(input logic [7:0] code, input logic [7:0] data);
    addr_phase(code);
    data_phase(data);
  endtask

  task automatic t_reset();
    check_all("R1");
  endtask

  task automatic t_clock_lane_and_latency();
    addr_phase(8'h34);
    ten = 1'b0; tdin = 8'hA5; cyc(4);
    tck = 1'b1;
    cyc(2);
    chk("R10", "clk_ctl early", {24'h0, clk_ctl}, {24'h0, m_clk});
    cyc(1);
    m_write(8'hA5);
    chk("R10", "clk_ctl on time", {24'h0, clk_ctl}, 32'hA5);
    cyc(4);
    check_all("R3");
    chk("R2", "dout addressed", {24'h0, tdout}, 32'hA5);
  endtask

  task automatic t_lanes();
    access(8'h44, 8'h3C);
    access(8'h54, 8'hC3);
    access(8'h84, 8'h7E);
    access(8'h94, 8'h81);
    check_all("R5");
    access(8'h75, 8'h04);
    check_all("R5");
  endtask

  task automatic t_crossed_phases();
    addr_phase(8'h34);
    ten = 1'b1; tdin = 8'hFF; cyc(4);
    tck = 1'b1; cyc(4);
    check_all("R4");
    ten = 1'b0; tdin = 8'h75; cyc(4);
    tck = 1'b0; cyc(4);
    check_all("R4");
    chk("R4", "dout after low-phase fall", {24'h0, tdout}, {24'h0, m_clk});
    tck = 1'b1; cyc(4);
    m_write(8'h75);
    check_all("R11");
  endtask

  task automatic t_repeat_data();
    addr_phase(8'h54);
    data_phase(8'h11);
    tck = 1'b0; cyc(4);
    data_phase(8'h6A);
    check_all("R11");
    chk("R11", "lane1", {24'h0, lane_ctl[15:8]}, 32'h6A);
  endtask

  task automatic t_unimpl();
    access(8'h20, 8'h99);
    check_all("R7");
    chk("R7", "dout unimpl", {24'h0, tdout}, 32'h0);
  endtask

  task automatic t_normal();
    access(8'h00, 8'h5A);
    check_all("R9");
    chk("R9", "normal", {31'h0, normal}, 32'h1);
  endtask

  task automatic t_clear();
    addr_phase(8'h94);
    data_phase(8'hEE);
    tclr = 1'b1; cyc(5);
    m_code = 8'h00; m_clk = 8'h00; m_settle = 8'h00;
    for (int i = 0; i < 4; i++) m_lane[i] = 8'h00;
    check_all("R6");
    tclr = 1'b0; cyc(4);
    check_all("R6");
  endtask

  initial begin
    rst_n = 1'b0; tck = 1'b1; ten = 1'b0; tclr = 1'b0; tdin = 8'h00;
    m_code = 8'h00; m_clk = 8'h00; m_settle = 8'h00;
    for (int i = 0; i < 4; i++) m_lane[i] = 8'h00;
    cyc(3);
    rst_n = 1'b1;
    cyc(4);
    t_reset();
    t_clock_lane_and_latency();
    t_lanes();
    t_crossed_phases();
    t_repeat_data();
    t_unimpl();
    t_normal();
    t_clear();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule